// File: doc/BRIEF.md
# Double-Buffered Timer-Based PWM Generator

This block drives one pulse-width modulated output from an 8-bit time base. Every count of the time base is split into four fine steps, so the duty setting has ten bits while the period register has only eight. A divider in front of the fine steps takes its ratio from a prescale select, so each fine step lasts 1, 4 or 16 input clocks. The period is therefore (P+1) × 4 × prescale clocks, and the high time is the 10-bit duty value × prescale clocks.

Software writes a master duty value at any time. The upper 8 bits come from a duty register and the lower 2 bits from a field in the control register. The master value is copied into an active compare register only at the period boundary, so a period that is already running always ends with the setting it started with. The active compare value is available as a read-only output. Clearing the enable bit stops the time base and holds the output low.

Top module: `pwm_gen`

## Requirements
- R1: After synchronous reset, `pwm_out` is 0 and `duty_active` is 0.
- R2: The output period, measured between rising edges, is (P+1)·4·N input clocks. P is the period register. N is 1 for prescale code 00, 4 for code 01, and 16 for codes 10 and 11. The time base returns to zero on the cycle after it completes count P.
- R3: Each period the output is high for D·N input clocks. D is the 10-bit duty value: the duty register gives bits 9:2 and control bits 2:1 give bits 1:0.
- R4: With D = 0 the output is never set and stays low.
- R5: When D ≥ 4·(P+1), the output is never cleared and stays high across periods.
- R6: A master duty write made in the middle of a period does not change that period. `duty_active` takes the new value at the next period boundary, and the following period uses it.
- R7: When control bit 0 (enable) is written to 0, the output is low within two clocks of the write and stays low.
- R8: The output rises only at a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_we | input | 1 | Write strobe for the period register |
| period_wdata | input | CNT_W | Period value P |
| duty_we | input | 1 | Write strobe for the upper duty bits |
| duty_wdata | input | CNT_W | Duty bits 9:2 |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 3 | Bit 0 enable, bits 2:1 duty bits 1:0 |
| pre_we | input | 1 | Write strobe for the prescale select |
| pre_wdata | input | 2 | Prescale code: 00 gives 1, 01 gives 4, 1x gives 16 |
| duty_active | output | CNT_W+2 | Active compare value, read-only |
| pwm_out | output | 1 | PWM output |

## Verification
The bench uses the default 8-bit counter width. A period of 255 is therefore reachable, and with it the 1023-of-1024 full-scale case, in which the compare value meets the very last fine step. All three prescale codes appear in the vectors, including the second code for divide-by-16. The smallest period (P=0) is also covered, where every period lasts only four fine steps.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // fine steps per time-base count, expressed as a bit width
    localparam int FINE_W = 2;
    // largest prescale ratio is 2**PRE_SHIFT_MAX
    localparam int PRE_SHIFT_MAX = 4;

    typedef enum logic [1:0] {
        PRE_DIV1   = 2'b00,
        PRE_DIV4   = 2'b01,
        PRE_DIV16A = 2'b10,
        PRE_DIV16B = 2'b11
    } pre_sel_e;

    typedef struct packed {
        logic [FINE_W-1:0] duty_lo;
        logic              en;
    } ctrl_t;

    function automatic int unsigned pre_shift(input pre_sel_e sel);
        case (sel)
            PRE_DIV1: return 0;
            PRE_DIV4: return 2;
            default:  return PRE_SHIFT_MAX;
        endcase
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = FINE_W + PRE_SHIFT_MAX
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [CNT_W-1:0]        period,
    input  pre_sel_e                pre_sel,
    output logic [CNT_W-1:0]        tmr_q,
    output logic [CNT_W+FINE_W-1:0] pos_nxt,
    output logic                    roll_nxt
);

    logic [DIV_W-1:0] div_q, div_d, div_lim;
    logic [CNT_W-1:0] tmr_d;
    int unsigned      shift;

    always_comb begin
        shift    = pre_shift(pre_sel);
        div_lim  = DIV_W'((32'd1 << (FINE_W + shift)) - 32'd1);
        div_d    = div_q;
        tmr_d    = tmr_q;
        roll_nxt = 1'b0;
        if (!en) begin
            div_d = '0;
            tmr_d = '0;
        end else if (div_q >= div_lim) begin
            div_d = '0;
            if (tmr_q == period) begin
                tmr_d    = '0;
                roll_nxt = 1'b1;
            end else begin
                tmr_d = tmr_q + 1'b1;
            end
        end else begin
            div_d = div_q + 1'b1;
        end
        pos_nxt = {tmr_d, FINE_W'(div_d >> shift)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            tmr_q <= '0;
        end else begin
            div_q <= div_d;
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DUTY_W-1:0] master,
    output logic [DUTY_W-1:0] slave
);

    always_ff @(posedge clk) begin
        if (rst)       slave <= '0;
        else if (load) slave <= master;
    end

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              roll_nxt,
    input  logic [DUTY_W-1:0] master,
    input  logic [DUTY_W-1:0] slave,
    input  logic [DUTY_W-1:0] pos_nxt,
    output logic              pwm_out
);

    logic out_d;

    always_comb begin
        out_d = pwm_out;
        if (!en)                    out_d = 1'b0;
        else if (roll_nxt)          out_d = (master != '0);
        else if (pos_nxt == slave)  out_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) pwm_out <= 1'b0;
        else     pwm_out <= out_d;
    end

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    period_we,
    input  logic [CNT_W-1:0]        period_wdata,
    input  logic                    duty_we,
    input  logic [CNT_W-1:0]        duty_wdata,
    input  logic                    ctrl_we,
    input  logic [FINE_W:0]         ctrl_wdata,
    input  logic                    pre_we,
    input  logic [1:0]              pre_wdata,
    output logic [CNT_W+FINE_W-1:0] duty_active,
    output logic                    pwm_out
);

    localparam int DUTY_W = CNT_W + FINE_W;
    localparam int DIV_W  = FINE_W + PRE_SHIFT_MAX;

    logic [CNT_W-1:0]  period_q;
    logic [CNT_W-1:0]  duty_hi_q;
    ctrl_t             ctrl_q;
    pre_sel_e          pre_q;
    logic              en_q;
    logic [DUTY_W-1:0] master;
    logic [DUTY_W-1:0] pos_nxt;
    logic [CNT_W-1:0]  tmr_q;
    logic              roll_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q  <= '0;
            duty_hi_q <= '0;
            ctrl_q    <= '0;
            pre_q     <= PRE_DIV1;
        end else begin
            if (period_we) period_q  <= period_wdata;
            if (duty_we)   duty_hi_q <= duty_wdata;
            if (ctrl_we)   ctrl_q    <= ctrl_t'(ctrl_wdata);
            if (pre_we)    pre_q     <= pre_sel_e'(pre_wdata);
        end
    end

    assign en_q   = ctrl_q.en;
    assign master = {duty_hi_q, ctrl_q.duty_lo};

    pwm_timebase #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .en       (en_q),
        .period   (period_q),
        .pre_sel  (pre_q),
        .tmr_q    (tmr_q),
        .pos_nxt  (pos_nxt),
        .roll_nxt (roll_nxt)
    );

    pwm_duty_buf #(.DUTY_W(DUTY_W)) u_buf (
        .clk    (clk),
        .rst    (rst),
        .load   (roll_nxt),
        .master (master),
        .slave  (duty_active)
    );

    pwm_out_stage #(.DUTY_W(DUTY_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .en       (en_q),
        .roll_nxt (roll_nxt),
        .master   (master),
        .slave    (duty_active),
        .pos_nxt  (pos_nxt),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
    parameter int CNT_W  = 8,
    parameter int DUTY_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              en_q,
    input logic              roll_nxt,
    input logic [CNT_W-1:0]  tmr_q,
    input logic [DUTY_W-1:0] duty_active,
    input logic              pwm_out
);

    // R2
    timer_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        roll_nxt |=> (tmr_q == '0));

    // R4
    zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (duty_active == '0) |-> !$rose(pwm_out));

    // R6
    slave_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !roll_nxt |=> $stable(duty_active));

    // R7
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !pwm_out);

    // R8
    rise_at_roll_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_out) |-> $past(roll_nxt));

endmodule

bind pwm_gen pwm_gen_chk #(.CNT_W(CNT_W), .DUTY_W(CNT_W + pwm_pkg::FINE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_q        (en_q),
    .roll_nxt    (roll_nxt),
    .tmr_q       (tmr_q),
    .duty_active (duty_active),
    .pwm_out     (pwm_out)
);

// File: tb/pwm_gen_test.sv
module pwm_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       period_we = 1'b0;
    logic [7:0] period_wdata = '0;
    logic       duty_we = 1'b0;
    logic [7:0] duty_wdata = '0;
    logic       ctrl_we = 1'b0;
    logic [2:0] ctrl_wdata = '0;
    logic       pre_we = 1'b0;
    logic [1:0] pre_wdata = '0;
    logic [9:0] duty_active;
    logic       pwm_out;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    pwm_gen uut (
        .clk(clk), .rst(rst),
        .period_we(period_we), .period_wdata(period_wdata),
        .duty_we(duty_we), .duty_wdata(duty_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .pre_we(pre_we), .pre_wdata(pre_wdata),
        .duty_active(duty_active), .pwm_out(pwm_out)
    );

    typedef struct packed {
        logic [1:0]  pre;
        logic [7:0]  per;
        logic [9:0]  duty;
        logic [15:0] hi;
        logic [15:0] prd;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 8'd9,   10'd10,   16'd10,   16'd40},
        '{2'b00, 8'd9,   10'd39,   16'd39,   16'd40},
        '{2'b01, 8'd4,   10'd7,    16'd28,   16'd80},
        '{2'b10, 8'd2,   10'd5,    16'd80,   16'd192},
        '{2'b00, 8'd0,   10'd1,    16'd1,    16'd4},
        '{2'b00, 8'd255, 10'd1023, 16'd1023, 16'd1024},
        '{2'b11, 8'd1,   10'd3,    16'd48,   16'd128}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic configure(input logic [1:0] pre, input logic [7:0] per,
                             input logic [9:0] duty);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = 3'b000;
        @(negedge clk);
        ctrl_we = 1'b0;
        period_we = 1'b1; period_wdata = per;
        pre_we = 1'b1; pre_wdata = pre;
        duty_we = 1'b1; duty_wdata = duty[9:2];
        @(negedge clk);
        period_we = 1'b0; pre_we = 1'b0; duty_we = 1'b0;
        ctrl_we = 1'b1; ctrl_wdata = {duty[1:0], 1'b1};
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    // wait until the output is seen rising at a negedge sample
    task automatic wait_rise(output bit ok);
        bit prev;
        ok = 1'b0;
        prev = pwm_out;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!prev && pwm_out) begin
                ok = 1'b1;
                break;
            end
            prev = pwm_out;
        end
    endtask

    // measure high time and period starting from a rise; optional mid-period write
    task automatic measure(input bit mid_write, output int hi, output int per);
        bit ok;
        bit seen_low;
        wait_rise(ok);
        hi = 0; per = 0;
        if (!ok) return;
        hi = 1; per = 1; seen_low = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            duty_we = 1'b0; ctrl_we = 1'b0;
            if (mid_write && per == 3) begin
                duty_we = 1'b1; duty_wdata = 8'd7;
                ctrl_we = 1'b1; ctrl_wdata = {2'b10, 1'b1};
            end
            if (!pwm_out) seen_low = 1'b1;
            else if (seen_low) break;
            per++;
            if (!seen_low) hi++;
        end
    endtask

    initial begin
        int hi, per, cnt;
        bit ok;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 pwm_out after reset", pwm_out, 0);
        check("R1 duty_active after reset", duty_active, 0);

        // R2 R3 R8: table of period and duty pairs
        for (int v = 0; v < NV; v++) begin
            configure(VECS[v].pre, VECS[v].per, VECS[v].duty);
            measure(1'b0, hi, per);
            check($sformatf("R3 high time vec %0d", v), hi, int'(VECS[v].hi));
            check($sformatf("R2 R8 period vec %0d", v), per, int'(VECS[v].prd));
            check($sformatf("R6 duty_active vec %0d", v), duty_active, int'(VECS[v].duty));
        end

        // R4: zero duty stays low
        configure(2'b00, 8'd3, 10'd0);
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pwm_out) cnt++;
        end
        check("R4 high samples with zero duty", cnt, 0);

        // R5: duty beyond period stays high
        configure(2'b00, 8'd3, 10'd100);
        wait_rise(ok);
        check("R5 first rise seen", ok, 1);
        cnt = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (!pwm_out) cnt++;
        end
        check("R5 low samples with duty above period", cnt, 0);

        // R6: mid-period write keeps current period
        configure(2'b00, 8'd9, 10'd10);
        measure(1'b1, hi, per);
        check("R6 high time of period with mid write", hi, 10);
        check("R6 duty_active after boundary", duty_active, 30);
        measure(1'b0, hi, per);
        check("R6 high time of following period", hi, 30);
        check("R6 period unchanged", per, 40);

        // R7: disable forces output low
        wait_rise(ok);
        @(negedge clk);
        check("R7 output high before disable", pwm_out, 1);
        ctrl_we = 1'b1; ctrl_wdata = 3'b100;
        @(negedge clk);
        ctrl_we = 1'b0;
        @(negedge clk);
        check("R7 output low after disable", pwm_out, 0);
        cnt = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (pwm_out) cnt++;
        end
        check("R7 output stays low while disabled", cnt, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule